// File: doc/BRIEF.md
# Real-Time Clock Calendar

This block keeps wall-clock time and a calendar date inside a single clock domain. A base tick input advances a small sub-second phase counter. Each time that phase completes, the seconds field advances. Carries ripple from seconds to minutes, then hours, then date and weekday, then month, then year. Month lengths are built in. February has 29 days in leap years. The year is held as two digits, covering 2000 to 2099, and a year value divisible by 4 is a leap year.

A host loads any single field through a valid/ready write port. The port never applies back-pressure: `wr_ready` is held high, so every cycle in which `wr_valid` is high is an accepted write. An accepted write also restarts the sub-second phase. If a tick arrives in the same cycle as a write, the tick is dropped. All fields are always visible as parallel outputs.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read second 0, minute 0, hour 0, weekday 0, date 1, month 1, year 0, and `wr_ready` is 1.
- R2: Seconds advance by one on every TICKS_PER_SEC-th tick pulse. Seconds and minutes wrap from 59 to 0, and each wrap carries into the next field. Hours wrap from 23 to 0.
- R3: An hour wrap advances the date and the weekday together. The weekday counts 0 to 6 and wraps from 6 to 0.
- R4: The date wraps to 1 after 30 in months 4, 6, 9 and 11. It wraps to 1 after 31 in months 1, 3, 5, 7, 8, 10 and 12. Each date wrap advances the month.
- R5: In month 2 the date wraps after 29 when the year's two low bits are 00, and after 28 otherwise. Year 0 counts as a leap year.
- R6: After 31 December the date becomes 1 January and the year advances. Year 99 wraps to 0.
- R7: A write loads `wr_data` into the field chosen by `wr_field`: 0 second, 1 minute, 2 hour, 3 weekday, 4 date, 5 month, 6 year. The new value is visible on the cycle after the write, and the other fields keep their values.
- R8: A write restarts the sub-second phase. A tick in the write cycle is ignored. The next second advance comes on the TICKS_PER_SEC-th tick after the write.
- R9: A write is accepted but has no effect when its value is out of range or `wr_field` is 7. The legal ranges are: second and minute 0..59, hour 0..23, weekday 0..6, date 1..31, month 1..12, year 0..99.
- R10: With no tick and no write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick pulse; TICKS_PER_SEC pulses make one second |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted; always 1 |
| wr_field | input | 3 | Field select code (see R7) |
| wr_data | input | 7 | Value to load |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hours |
| wday_o | output | 3 | Weekday 0..6 |
| date_o | output | 5 | Day of month 1..31 |
| month_o | output | 4 | Month 1..12 |
| year_o | output | 7 | Year 0..99 (2000..2099) |

## Verification
The embedded assertions check these behaviours on every cycle:
- each field's wrap on a carry and its hold when idle;
- the weekday, year and February leap and common-year rollovers;
- an out-of-range seconds write leaving seconds untouched;
- the cycle after a write producing no second pulse.

Only the bench's scenarios can show the rest. That covers whole carry chains running from seconds up to the year, how the phase count relates to tick pulses spread over gaps, and field-by-field loading with the other fields left intact. The bench does this by comparing every cycle against a behavioural calendar model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W = 3;
  localparam int DATA_W  = 7;
  localparam int NFIELDS = 7;

  typedef enum logic [FIELD_W-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DATE = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_NONE = 3'd7
  } field_e;

  // lowest legal value of a field
  function automatic logic [DATA_W-1:0] field_floor(input int idx);
    return (idx == int'(FLD_DATE) || idx == int'(FLD_MON)) ? 7'd1 : 7'd0;
  endfunction

  // highest legal value a host may write
  function automatic logic [DATA_W-1:0] field_ceil(input int idx);
    case (idx)
      0, 1:    return 7'd59;
      2:       return 7'd23;
      3:       return 7'd6;
      4:       return 7'd31;
      5:       return 7'd12;
      default: return 7'd99;
    endcase
  endfunction

  function automatic logic year_is_leap(input logic [DATA_W-1:0] yr);
    return yr[1:0] == 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] days_in_month(input logic [DATA_W-1:0] mon,
                                                       input logic leap);
    case (mon)
      7'd2:                      return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic sec_pulse
);
  localparam int PH_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (clr)    phase <= '0;
    else if (tick)   phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
  end

  assign sec_pulse = tick && !clr && (phase == PH_LAST);

  // R8: the cycle after a write restarts the phase, so no second pulse follows
  a_r8_restart_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (TICKS > 1) && clr |=> !sec_pulse);
endmodule

// File: rtl/rtc_field_ctr.sv
module rtc_field_ctr #(
  parameter int W = 7,
  parameter logic [W-1:0] FLOOR = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] lim,
  output logic [W-1:0] val,
  output logic         carry
);
  logic at_top;
  assign at_top = (val >= lim);
  assign carry  = inc && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= FLOOR;
    else if (ld)   val <= ld_val;
    else if (inc)  val <= at_top ? FLOOR : val + 1'b1;
  end

  // R2: a carry-out wraps the field to its floor
  a_r2_field_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !ld && (val >= lim) |=> val == FLOOR);
  // R10: idle field holds
  a_r10_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !ld |=> $stable(val));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [2:0]   wr_field,
  input  logic [6:0]   wr_data,
  output logic [5:0]   sec_o,
  output logic [5:0]   min_o,
  output logic [4:0]   hour_o,
  output logic [2:0]   wday_o,
  output logic [4:0]   date_o,
  output logic [3:0]   month_o,
  output logic [6:0]   year_o
);
  logic                  wr_acc;
  logic                  sec_pulse;
  logic [NFIELDS-1:0]    inc, carry, ld;
  logic [DATA_W-1:0]     val [NFIELDS];
  logic [DATA_W-1:0]     lim [NFIELDS];
  logic                  leap;
  logic [DATA_W-1:0]     mlen;

  assign wr_ready = 1'b1;
  assign wr_acc   = wr_valid && wr_ready;

  rtc_subsec #(.TICKS(TICKS_PER_SEC)) u_subsec (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_i),
    .clr       (wr_acc),
    .sec_pulse (sec_pulse)
  );

  assign leap = year_is_leap(val[FLD_YEAR]);
  assign mlen = days_in_month(val[FLD_MON], leap);

  // carry chain: sec -> min -> hour -> {date, wday}; date -> month -> year
  assign inc[FLD_SEC]  = sec_pulse;
  assign inc[FLD_MIN]  = carry[FLD_SEC];
  assign inc[FLD_HOUR] = carry[FLD_MIN];
  assign inc[FLD_WDAY] = carry[FLD_HOUR];
  assign inc[FLD_DATE] = carry[FLD_HOUR];
  assign inc[FLD_MON]  = carry[FLD_DATE];
  assign inc[FLD_YEAR] = carry[FLD_MON];

  for (genvar g = 0; g < NFIELDS; g++) begin : g_field
    localparam logic [DATA_W-1:0] FLOOR = field_floor(g);
    localparam logic [DATA_W-1:0] CEIL  = field_ceil(g);

    assign lim[g] = (g == int'(FLD_DATE)) ? mlen : CEIL;
    assign ld[g]  = wr_acc && (wr_field == FIELD_W'(g)) &&
                    (wr_data >= FLOOR) && (wr_data <= CEIL);

    rtc_field_ctr #(.W(DATA_W), .FLOOR(FLOOR)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc[g]),
      .ld     (ld[g]),
      .ld_val (wr_data),
      .lim    (lim[g]),
      .val    (val[g]),
      .carry  (carry[g])
    );
  end

  assign sec_o   = val[FLD_SEC][5:0];
  assign min_o   = val[FLD_MIN][5:0];
  assign hour_o  = val[FLD_HOUR][4:0];
  assign wday_o  = val[FLD_WDAY][2:0];
  assign date_o  = val[FLD_DATE][4:0];
  assign month_o = val[FLD_MON][3:0];
  assign year_o  = val[FLD_YEAR];

  // R3: weekday wraps 6 -> 0 on a day change
  a_r3_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    carry[FLD_HOUR] && wday_o == 3'd6 |=> wday_o == 3'd0);
  // R3: weekday never leaves its range
  a_r3_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
    wday_o <= 3'd6);
  // R4: a thirty-day month wraps after day 30
  a_r4_short_month: assert property (@(posedge clk) disable iff (!rst_n)
    carry[FLD_HOUR] && month_o == 4'd4 && date_o == 5'd30 |=> date_o == 5'd1 && month_o == 4'd5);
  // R5: leap February reaches day 29
  a_r5_leap_feb: assert property (@(posedge clk) disable iff (!rst_n)
    carry[FLD_HOUR] && month_o == 4'd2 && date_o == 5'd28 && year_o[1:0] == 2'b00 |=> date_o == 5'd29);
  // R5: common-year February ends on day 28
  a_r5_common_feb: assert property (@(posedge clk) disable iff (!rst_n)
    carry[FLD_HOUR] && month_o == 4'd2 && date_o == 5'd28 && year_o[1:0] != 2'b00
    |=> date_o == 5'd1 && month_o == 4'd3);
  // R6: year 99 wraps to 0 on year carry
  a_r6_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    carry[FLD_MON] && year_o == 7'd99 |=> year_o == 7'd0);
  // R9: out-of-range seconds write leaves seconds untouched
  a_r9_bad_sec_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_field == 3'd0 && wr_data > 7'd59 |=> $stable(sec_o));
endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [2:0] wr_field = 3'd0;
  logic [6:0] wr_data = 7'd0;
  logic [5:0] sec_o, min_o;
  logic [4:0] hour_o, date_o;
  logic [2:0] wday_o;
  logic [3:0] month_o;
  logic [6:0] year_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // reference model state
  int m_sec, m_min, m_hr, m_wd, m_dt, m_mo, m_yr, m_ph;

  always #2.5 clk = ~clk;  // 200 MHz

  rtc_calendar #(.TICKS_PER_SEC(TPS)) i_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_field(wr_field), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .wday_o(wday_o), .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit legal(int f, int v);
    case (f)
      0, 1: return v <= 59;
      2:    return v <= 23;
      3:    return v <= 6;
      4:    return v >= 1 && v <= 31;
      5:    return v >= 1 && v <= 12;
      6:    return v <= 99;
      default: return 0;
    endcase
  endfunction

  task automatic model_second();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd + 1) % 7;
    if (m_dt >= mdays(m_mo, m_yr)) begin
      m_dt = 1;
      if (m_mo >= 12) begin
        m_mo = 1;
        m_yr = (m_yr + 1) % 100;
      end else m_mo++;
    end else m_dt++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_dt = 1; m_mo = 1; m_yr = 0; m_ph = 0;
    end else if (wr_valid) begin
      m_ph = 0;
      if (legal(int'(wr_field), int'(wr_data)))
        case (wr_field)
          3'd0: m_sec = wr_data;
          3'd1: m_min = wr_data;
          3'd2: m_hr  = wr_data;
          3'd3: m_wd  = wr_data;
          3'd4: m_dt  = wr_data;
          3'd5: m_mo  = wr_data;
          3'd6: m_yr  = wr_data;
          default: ;
        endcase
    end else if (tick_i) begin
      m_ph++;
      if (m_ph == TPS) begin
        m_ph = 0;
        model_second();
      end
    end
  end

  task automatic compare_all();
    int act [7];
    int exp_v [7];
    act   = '{int'(sec_o), int'(min_o), int'(hour_o), int'(wday_o), int'(date_o), int'(month_o), int'(year_o)};
    exp_v = '{m_sec, m_min, m_hr, m_wd, m_dt, m_mo, m_yr};
    checks++;
    if (act != exp_v || wr_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s model: actual s%0d m%0d h%0d w%0d d%0d mo%0d y%0d rdy%0b expected s%0d m%0d h%0d w%0d d%0d mo%0d y%0d rdy1",
               cur_req, act[0], act[1], act[2], act[3], act[4], act[5], act[6], wr_ready,
               exp_v[0], exp_v[1], exp_v[2], exp_v[3], exp_v[4], exp_v[5], exp_v[6]);
    end
  endtask

  task automatic chk(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // one clock: drive inputs, let the edge pass, compare at the falling edge
  task automatic step(bit t, bit wv, int f, int d);
    tick_i = t; wr_valid = wv; wr_field = 3'(f); wr_data = 7'(d);
    @(negedge clk);
    tick_i = 0; wr_valid = 0;
    compare_all();
  endtask

  task automatic wr(int f, int d);
    step(0, 1, f, d);
  endtask

  task automatic secs(int n);
    for (int i = 0; i < n * TPS; i++) step(1, 0, 0, 0);
  endtask

  task automatic set_all(int s, int mi, int h, int w, int d, int mo, int y);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    compare_all();
    chk("R1 date", date_o, 1); chk("R1 month", month_o, 1); chk("R1 ready", wr_ready, 1);

    // R2/R10: ticks with gaps
    cur_req = "R2";
    for (int i = 0; i < 10 * TPS; i++) begin
      step(1, 0, 0, 0);
      if (i % 3 == 0) step(0, 0, 0, 0);
    end
    chk("R2 seconds", sec_o, 10);
    cur_req = "R10";
    repeat (6) step(0, 0, 0, 0);
    chk("R10 hold", sec_o, 10);

    // R2: minute carry
    cur_req = "R2";
    wr(0, 59); wr(1, 7);
    secs(1);
    chk("R2 min carry sec", sec_o, 0); chk("R2 min carry", min_o, 8);

    // R3: day rollover with weekday wrap
    cur_req = "R3";
    set_all(59, 59, 23, 6, 10, 3, 21);
    secs(1);
    chk("R3 hour", hour_o, 0); chk("R3 wday", wday_o, 0); chk("R3 date", date_o, 11);

    // R4: thirty and thirty-one day months
    cur_req = "R4";
    set_all(59, 59, 23, 2, 30, 4, 21);
    secs(1);
    chk("R4 apr date", date_o, 1); chk("R4 apr month", month_o, 5);
    set_all(59, 59, 23, 2, 30, 1, 21);
    secs(1);
    chk("R4 jan 31", date_o, 31);
    set_all(59, 59, 23, 2, 31, 1, 21);
    secs(1);
    chk("R4 jan end", month_o, 2);

    // R5: February
    cur_req = "R5";
    set_all(59, 59, 23, 0, 28, 2, 23);
    secs(1);
    chk("R5 common feb", month_o, 3);
    set_all(59, 59, 23, 0, 28, 2, 24);
    secs(1);
    chk("R5 leap feb 29", date_o, 29);
    set_all(59, 59, 23, 0, 29, 2, 0);
    secs(1);
    chk("R5 year 0 leap end", month_o, 3);
    set_all(59, 59, 23, 0, 28, 2, 0);
    secs(1);
    chk("R5 year 0 day 29", date_o, 29);

    // R6: year end and century wrap
    cur_req = "R6";
    set_all(59, 59, 23, 5, 31, 12, 99);
    secs(1);
    chk("R6 year wrap", year_o, 0); chk("R6 month", month_o, 1); chk("R6 date", date_o, 1);
    set_all(59, 59, 23, 5, 31, 12, 41);
    secs(1);
    chk("R6 year inc", year_o, 42);

    // R7: single-field writes
    cur_req = "R7";
    wr(2, 17);
    chk("R7 hour", hour_o, 17); chk("R7 others", year_o, 42);
    wr(3, 4);
    chk("R7 wday", wday_o, 4);

    // R8: phase restart and dropped tick
    cur_req = "R8";
    wr(0, 20);
    repeat (TPS - 1) step(1, 0, 0, 0);
    step(1, 1, 1, 33);
    chk("R8 tick dropped", sec_o, 20);
    repeat (TPS - 1) step(1, 0, 0, 0);
    chk("R8 not yet", sec_o, 20);
    step(1, 0, 0, 0);
    chk("R8 advance", sec_o, 21);

    // R9: rejected writes
    cur_req = "R9";
    wr(0, 60); chk("R9 sec 60", sec_o, 21);
    wr(5, 13); chk("R9 month 13", month_o, 1);
    wr(4, 0);  chk("R9 date 0", date_o, 1);
    wr(2, 24); chk("R9 hour 24", hour_o, 17);
    wr(7, 5);  chk("R9 field 7", sec_o, 21);
    wr(6, 100); chk("R9 year 100", year_o, 42);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule